// File: doc/BRIEF.md
# Two-Wire Host Controller for Indexed Byte Reads

This block is a bus host that software runs through five byte-wide registers. Software chooses a target device and an index byte, sets a start bit and then polls a status byte. The controller then fetches one byte from that device over an open-drain clock/data pair. The block runs a fixed frame:

- a start condition, then the device address with the write bit, then the index byte;
- a repeated start, then the same address with the read bit;
- one data byte, which the host answers with a not-acknowledge, then a stop condition.

Completion is reported as a success flag or a device-error flag. Both flags are write-one-to-clear. An interrupt line follows the flags when it is enabled.

Both bus lines leave the block as pull-low enables, so a pad or an external resistor supplies the high level. The data line comes back as an input for sampling. The bit rate is set by a parameter that gives the number of system clocks in each quarter of a bit. The reset input is asynchronous and active-low, and the block releases it internally through two flops.

Register offsets: 0 status, 1 control, 2 device address, 3 index, 4 data.

Top module: `smbh_host`

## Requirements
- R1: After reset every register reads 0x00, both pull-low outputs are 0 and the interrupt output is 0.
- R2: Status bit 0 (busy) reads 1 from the clock edge that takes a control write with bit 6 set until the stop condition has completed.
- R3: A frame in which every address and index byte is acknowledged ends with status reading exactly 0x02 (bit 1, success) and with the data register (offset 4) holding the received byte, MSB first.
- R4: Writing 1 to status bit 1 or bit 2 clears that bit. Writing 0 leaves it unchanged.
- R5: Control bits 7, 5:0 are stored and read back, with bits 4:2 as the protocol field (2 selects the indexed byte read). Control bit 6 always reads 0.
- R6: A control write with bit 6 set while busy is 1 does not restart or extend the frame: the frame still has exactly two start conditions.
- R7: Each frame shows two start conditions and one stop condition on the bus. The data line changes while the clock line is high only at those conditions, and both lines are released whenever busy is 0.
- R8: The address byte sent first is {device[7:1], 0}, then the index byte (offset 3), and after the repeated start {device[7:1], 1}.
- R9: The interrupt output equals control bit 0 AND (status bit 1 OR status bit 2).
- R10: A not-acknowledge on an address or index byte ends the frame with a stop condition. Status then reads exactly 0x04 (bit 2, device error) and the data register keeps its earlier value.
- R11: The clock line is released for 2*QTR_DIV system clocks in each bit, out of a bit period of 4*QTR_DIV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register offset for read and write |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| irq | output | 1 | Completion interrupt (level) |
| scl_pull | output | 1 | 1 pulls the clock line low |
| sda_pull | output | 1 | 1 pulls the data line low |
| sda_in | input | 1 | Sampled level of the data line |

## Verification
The bench builds the controller with QTR_DIV = 4, so one bit takes 16 system clocks and a full frame takes under a thousand. That is short enough to run five complete frames, several of which end early on a not-acknowledge. A behavioural target on the bench side acknowledges one address and returns the index XOR 0x3C, and it can refuse the index byte on request. This lets both error paths be reached next to the successful read. It also lets the bench measure the released-clock width against 2*QTR_DIV.

// File: rtl/smbh_pkg.sv
`timescale 1ns/1ps
package smbh_pkg;
  // register offsets
  localparam logic [2:0] OFS_STAT = 3'd0;
  localparam logic [2:0] OFS_CTRL = 3'd1;
  localparam logic [2:0] OFS_DEV  = 3'd2;
  localparam logic [2:0] OFS_IDX  = 3'd3;
  localparam logic [2:0] OFS_DATA = 3'd4;
  // bit positions
  localparam int STAT_OK  = 1;
  localparam int STAT_ERR = 2;
  localparam int CTRL_GO  = 6;
  localparam int CTRL_IEN = 0;

  typedef enum logic [2:0] {
    SYM_IDLE, SYM_START1, SYM_ADDRW, SYM_IDX,
    SYM_START2, SYM_ADDRR, SYM_DATA, SYM_STOP
  } sym_e;
endpackage

// File: rtl/smbh_qtick.sv
`timescale 1ns/1ps
module smbh_qtick #(
  parameter int QTR_DIV = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(QTR_DIV + 1);
  localparam logic [CW-1:0] LAST = CW'(QTR_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    tick  = run && (cnt_q == LAST);
    cnt_n = (!run || tick) ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/smbh_engine.sv
`timescale 1ns/1ps
module smbh_engine
  import smbh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       go,
  input  logic [6:0] dev_addr,
  input  logic [7:0] idx_byte,
  input  logic       sda_in,
  output logic       busy,
  output logic       scl_low,
  output logic       sda_low,
  output logic       done_ok,
  output logic       done_err,
  output logic       in_cond,
  output logic [7:0] rx_byte
);
  sym_e       sym_q, sym_n;
  logic [1:0] q_q, q_n;
  logic [3:0] bit_q, bit_n;
  logic [7:0] sh_q, sh_n;
  logic       nack_q, nack_n, scl_q, scl_n, sda_q, sda_n;
  logic [7:0] tx_byte;
  logic       tx_sym, last_bit, end_tick;

  always_comb begin
    unique case (sym_q)
      SYM_ADDRW: tx_byte = {dev_addr, 1'b0};
      SYM_ADDRR: tx_byte = {dev_addr, 1'b1};
      default:   tx_byte = idx_byte;
    endcase
    tx_sym   = (sym_q == SYM_ADDRW) || (sym_q == SYM_IDX) || (sym_q == SYM_ADDRR);
    last_bit = (bit_q == 4'd8);
    end_tick = tick && (q_q == 2'd3);
  end

  // each bit: q0 clock low, q1 data set, q2/q3 clock released, sample entering q3
  always_comb begin
    sym_n  = sym_q;
    q_n    = q_q;
    bit_n  = bit_q;
    sh_n   = sh_q;
    nack_n = nack_q;
    scl_n  = scl_q;
    sda_n  = sda_q;
    if (sym_q == SYM_IDLE) begin
      if (go) begin
        sym_n  = SYM_START1;
        q_n    = 2'd0;
        bit_n  = 4'd0;
        nack_n = 1'b0;
        scl_n  = 1'b1;
      end
    end else if (tick) begin
      q_n = q_q + 2'd1;
      unique case (q_q)
        2'd0: begin
          if (sym_q == SYM_STOP)         sda_n = 1'b1;
          else if (tx_sym && !last_bit)  sda_n = ~tx_byte[3'd7 - bit_q[2:0]];
          else                           sda_n = 1'b0;
        end
        2'd1: scl_n = 1'b0;
        2'd2: begin
          if (sym_q == SYM_START1 || sym_q == SYM_START2) sda_n = 1'b1;
          else if (sym_q == SYM_STOP)                     sda_n = 1'b0;
          else if (tx_sym && last_bit)                    nack_n = sda_in;
          else if (sym_q == SYM_DATA && !last_bit)        sh_n = {sh_q[6:0], sda_in};
        end
        default: begin
          scl_n = 1'b1;
          bit_n = bit_q + 4'd1;
          unique case (sym_q)
            SYM_START1: begin sym_n = SYM_ADDRW; bit_n = 4'd0; end
            SYM_START2: begin sym_n = SYM_ADDRR; bit_n = 4'd0; end
            SYM_ADDRW, SYM_IDX, SYM_ADDRR: begin
              if (last_bit) begin
                bit_n = 4'd0;
                if (nack_q)                  sym_n = SYM_STOP;
                else if (sym_q == SYM_ADDRW) sym_n = SYM_IDX;
                else if (sym_q == SYM_IDX)   sym_n = SYM_START2;
                else                         sym_n = SYM_DATA;
              end
            end
            SYM_DATA: if (last_bit) begin sym_n = SYM_STOP; bit_n = 4'd0; end
            SYM_STOP: begin sym_n = SYM_IDLE; scl_n = 1'b0; bit_n = 4'd0; end
            default:  sym_n = SYM_IDLE;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_q  <= SYM_IDLE;
      q_q    <= 2'd0;
      bit_q  <= 4'd0;
      sh_q   <= 8'd0;
      nack_q <= 1'b0;
      scl_q  <= 1'b0;
      sda_q  <= 1'b0;
    end else begin
      sym_q  <= sym_n;
      q_q    <= q_n;
      bit_q  <= bit_n;
      sh_q   <= sh_n;
      nack_q <= nack_n;
      scl_q  <= scl_n;
      sda_q  <= sda_n;
    end
  end

  assign busy     = (sym_q != SYM_IDLE);
  assign scl_low  = scl_q;
  assign sda_low  = sda_q;
  assign done_ok  = end_tick && (sym_q == SYM_STOP) && !nack_q;
  assign done_err = end_tick && (sym_q == SYM_STOP) && nack_q;
  assign in_cond  = (sym_q == SYM_START1) || (sym_q == SYM_START2) || (sym_q == SYM_STOP);
  assign rx_byte  = sh_q;
endmodule

// File: rtl/smbh_regs.sv
`timescale 1ns/1ps
module smbh_regs
  import smbh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  input  logic       busy,
  input  logic       done_ok,
  input  logic       done_err,
  input  logic [7:0] rx_byte,
  output logic [7:0] reg_rdata,
  output logic       go,
  output logic       ien,
  output logic [6:0] dev_addr,
  output logic [7:0] idx_byte,
  output logic       st_ok,
  output logic       st_err,
  output logic       irq
);
  logic [7:0] ctrl_q, ctrl_n, dev_q, dev_n, idx_q, idx_n, data_q, data_n;
  logic       ok_q, ok_n, err_q, err_n;
  logic       wr_stat, wr_ctrl;

  always_comb begin
    wr_stat = reg_wr && (reg_addr == OFS_STAT);
    wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
    go      = wr_ctrl && reg_wdata[CTRL_GO] && !busy;

    ctrl_n = wr_ctrl ? (reg_wdata & ~(8'd1 << CTRL_GO)) : ctrl_q;
    dev_n  = (reg_wr && reg_addr == OFS_DEV) ? reg_wdata : dev_q;
    idx_n  = (reg_wr && reg_addr == OFS_IDX) ? reg_wdata : idx_q;
    if (done_ok)                           data_n = rx_byte;
    else if (reg_wr && reg_addr == OFS_DATA) data_n = reg_wdata;
    else                                   data_n = data_q;

    if (done_ok)                         ok_n = 1'b1;
    else if (wr_stat && reg_wdata[STAT_OK]) ok_n = 1'b0;
    else                                 ok_n = ok_q;
    if (done_err)                          err_n = 1'b1;
    else if (wr_stat && reg_wdata[STAT_ERR]) err_n = 1'b0;
    else                                   err_n = err_q;

    unique case (reg_addr)
      OFS_STAT: reg_rdata = {5'd0, err_q, ok_q, busy};
      OFS_CTRL: reg_rdata = ctrl_q;
      OFS_DEV:  reg_rdata = dev_q;
      OFS_IDX:  reg_rdata = idx_q;
      OFS_DATA: reg_rdata = data_q;
      default:  reg_rdata = 8'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 8'd0;
      dev_q  <= 8'd0;
      idx_q  <= 8'd0;
      data_q <= 8'd0;
      ok_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      dev_q  <= dev_n;
      idx_q  <= idx_n;
      data_q <= data_n;
      ok_q   <= ok_n;
      err_q  <= err_n;
    end
  end

  assign ien      = ctrl_q[CTRL_IEN];
  assign dev_addr = dev_q[7:1];
  assign idx_byte = idx_q;
  assign st_ok    = ok_q;
  assign st_err   = err_q;
  assign irq      = ctrl_q[CTRL_IEN] && (ok_q || err_q);
endmodule

// File: rtl/smbh_host.sv
`timescale 1ns/1ps
module smbh_host #(
  parameter int QTR_DIV = 125
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       scl_pull,
  output logic       sda_pull,
  input  logic       sda_in
);
  logic [1:0] rsync_q;
  logic       rst_i;
  logic       tick, go, busy, done_ok, done_err, in_cond, ien, st_ok, st_err;
  logic [6:0] dev_addr;
  logic [7:0] idx_byte, rx_byte;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  smbh_qtick #(.QTR_DIV(QTR_DIV)) u_qtick (
    .clk(clk), .rst_n(rst_i), .run(busy), .tick(tick)
  );

  smbh_regs u_regs (
    .clk(clk), .rst_n(rst_i), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .busy(busy), .done_ok(done_ok), .done_err(done_err),
    .rx_byte(rx_byte), .reg_rdata(reg_rdata), .go(go), .ien(ien),
    .dev_addr(dev_addr), .idx_byte(idx_byte), .st_ok(st_ok), .st_err(st_err),
    .irq(irq)
  );

  smbh_engine u_engine (
    .clk(clk), .rst_n(rst_i), .tick(tick), .go(go), .dev_addr(dev_addr),
    .idx_byte(idx_byte), .sda_in(sda_in), .busy(busy), .scl_low(scl_pull),
    .sda_low(sda_pull), .done_ok(done_ok), .done_err(done_err),
    .in_cond(in_cond), .rx_byte(rx_byte)
  );
endmodule

// File: rtl/smbh_host_chk.sv
`timescale 1ns/1ps
module smbh_host_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] reg_addr,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       irq,
  input logic       scl_pull,
  input logic       sda_pull,
  input logic       busy,
  input logic       ien,
  input logic       st_ok,
  input logic       st_err,
  input logic       in_cond
);
  AST_GO_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd1 && reg_wdata[6] && !busy) |=> busy); // R2
  AST_BUSY_NEEDS_GO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && reg_addr == 3'd1 && reg_wdata[6])); // R6
  AST_FLAG_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(st_ok) || $rose(st_err)) |-> $fell(busy)); // R3
  AST_GO_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd1) |-> !reg_rdata[6]); // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien && (st_ok || st_err))); // R9
  AST_SDA_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_pull && !$past(scl_pull) && (sda_pull != $past(sda_pull))) |-> in_cond); // R7
  AST_LINES_FREE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_pull && !sda_pull)); // R7
endmodule

bind smbh_host smbh_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .scl_pull(scl_pull),
  .sda_pull(sda_pull), .busy(busy), .ien(ien), .st_ok(st_ok), .st_err(st_err),
  .in_cond(in_cond)
);

// File: tb/test_smbh_host.sv
`timescale 1ns/1ps
module test_smbh_host;
  localparam int QD = 4;

  logic       clk, rst_n, reg_wr;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       irq, scl_pull, sda_pull;
  wire        scl_bus, sda_bus;

  int n_chk = 0, n_err = 0, cyc = 0;
  logic s_low = 1'b0;

  smbh_host #(.QTR_DIV(QD)) i_smbh_host (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .sda_in(sda_bus)
  );

  assign scl_bus = !scl_pull;
  assign sda_bus = !(sda_pull || s_low);

  initial clk = 1'b0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  // bus target model: device 0x50, returns index ^ 0x3C
  localparam logic [6:0] TGT = 7'h50;
  int n_start = 0, n_stop = 0, bc = 0, ph = 0, t_rise = 0, hi_len = 0;
  logic act = 1'b0, acked = 1'b0, nack_idx = 1'b0;
  logic [7:0] sh = 8'd0, dout = 8'd0, cap_aw = 8'd0, cap_ar = 8'd0, cap_idx = 8'd0;

  always @(negedge sda_bus) if (scl_bus === 1'b1 && rst_n) begin
    n_start++; act = 1'b1; bc = 0; ph = 0; acked = 1'b0; s_low = 1'b0;
  end
  always @(posedge sda_bus) if (scl_bus === 1'b1 && rst_n) begin
    n_stop++; act = 1'b0; s_low = 1'b0;
  end
  always @(posedge scl_bus) begin
    t_rise = cyc;
    if (act) begin
      if (bc < 8) begin
        if (ph != 2) sh = {sh[6:0], sda_bus};
        bc++;
      end else if (bc == 8) bc = 9;
    end
  end
  always @(negedge scl_bus) begin
    hi_len = cyc - t_rise;
    if (act) begin
      if (bc == 8 && ph != 2 && !acked) begin
        acked = 1'b1;
        if (ph == 0) begin
          if (sh[7:1] == TGT) begin
            s_low = 1'b1;
            if (sh[0]) cap_ar = sh; else cap_aw = sh;
          end else act = 1'b0;
        end else begin
          cap_idx = sh; dout = sh ^ 8'h3C; s_low = !nack_idx;
        end
      end else if (bc == 9) begin
        s_low = 1'b0; bc = 0; acked = 1'b0;
        if (ph == 0 && sh[0]) begin ph = 2; s_low = !dout[7]; end
        else if (ph == 0) ph = 1;
        else if (ph == 2) act = 1'b0;
      end else if (ph == 2 && bc >= 1 && bc <= 7) s_low = !dout[7-bc];
      else if (ph == 2 && bc == 8) s_low = 1'b0;
    end
  end

  task automatic check(input string req, input logic [7:0] actv, input logic [7:0] expv);
    n_chk++;
    if (actv !== expv) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, actv, expv);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle(output logic [7:0] st);
    for (int i = 0; i < 5000; i++) begin
      rd(3'd0, st);
      if (!st[0]) break;
    end
  endtask

  // prepare registers, launch a frame, optionally poke start mid-frame, wait for end
  task automatic run_frame(input logic [6:0] dev, input logic [7:0] idx, input logic [7:0] pre,
                           input logic [7:0] ctl, input bit poke, output logic [7:0] st);
    logic [7:0] v;
    wr(3'd2, {dev, 1'b1});
    wr(3'd3, idx);
    rd(3'd0, v); wr(3'd0, v);
    wr(3'd4, pre);
    n_start = 0; n_stop = 0;
    wr(3'd1, ctl | 8'h40);
    rd(3'd0, v); check("R2 busy after start", v & 8'h01, 8'h01);
    if (poke) begin
      repeat (100) @(negedge clk);
      wr(3'd1, ctl | 8'h40);
    end
    wait_idle(st);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v); check("R1 register reset", v, 8'h00);
    end
    check("R1 lines released", {6'd0, scl_pull, sda_pull}, 8'h00);
    check("R1 irq low", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_ctrl;
    logic [7:0] v;
    wr(3'd1, 8'hA9);
    rd(3'd1, v); check("R5 control readback", v, 8'hA9);
    rd(3'd0, v); check("R5 no start without bit6", v, 8'h00);
  endtask

  task automatic t_good_read;
    logic [7:0] st, v;
    run_frame(7'h50, 8'h12, 8'h00, 8'h09, 1'b0, st);
    check("R3 status success", st, 8'h02);
    rd(3'd4, v); check("R3 data byte", v, 8'h2E);
    rd(3'd1, v); check("R5 start reads zero", v, 8'h09);
    check("R7 start count", 8'(n_start), 8'd2);
    check("R7 stop count", 8'(n_stop), 8'd1);
    check("R8 address write", cap_aw, 8'hA0);
    check("R8 index byte", cap_idx, 8'h12);
    check("R8 address read", cap_ar, 8'hA1);
    check("R9 irq on success", {7'd0, irq}, 8'h01);
    check("R11 clock high width", 8'(hi_len), 8'(2 * QD));
  endtask

  task automatic t_w1c;
    logic [7:0] v;
    wr(3'd0, 8'h00);
    rd(3'd0, v); check("R4 zero write keeps flag", v, 8'h02);
    wr(3'd0, 8'h02);
    rd(3'd0, v); check("R4 one write clears flag", v, 8'h00);
    check("R9 irq drops", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_busy_start;
    logic [7:0] st, v;
    run_frame(7'h50, 8'hF0, 8'h00, 8'h09, 1'b1, st);
    check("R6 frame completes", st, 8'h02);
    rd(3'd4, v); check("R6 data byte", v, 8'hCC);
    repeat (100) @(negedge clk);
    rd(3'd0, v); check("R6 no restart", v, 8'h02);
    check("R6 start count", 8'(n_start), 8'd2);
  endtask

  task automatic t_addr_nack;
    logic [7:0] st, v;
    run_frame(7'h33, 8'h01, 8'h5A, 8'h09, 1'b0, st);
    check("R10 address nack status", st, 8'h04);
    rd(3'd4, v); check("R10 data kept", v, 8'h5A);
    check("R10 stop sent", 8'(n_stop), 8'd1);
    check("R9 irq on error", {7'd0, irq}, 8'h01);
  endtask

  task automatic t_idx_nack;
    logic [7:0] st;
    nack_idx = 1'b1;
    run_frame(7'h50, 8'h07, 8'h11, 8'h09, 1'b0, st);
    nack_idx = 1'b0;
    check("R10 index nack status", st, 8'h04);
    check("R10 one start only", 8'(n_start), 8'd1);
  endtask

  task automatic t_irq_off;
    logic [7:0] st;
    run_frame(7'h50, 8'h3C, 8'h00, 8'h08, 1'b0, st);
    check("R9 status success", st, 8'h02);
    check("R9 irq masked", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog R2 actual=busy expected=idle");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = 8'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ctrl();
    t_good_read();
    t_w1c();
    t_busy_start();
    t_addr_nack();
    t_idx_nack();
    t_irq_off();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule